// File: doc/BRIEF.md
# Program-Counter Action Profiler

This block is a passive timing monitor that sits beside a soft processor and watches the program-counter trace, one value per clock. It never halts or interrupts the processor and adds no code to the program. Software loads three address tables at run time. The first holds, for each actor, the address where that actor's scheduler evaluation routine begins. The other two hold, for each action, the address where the action starts and the address where it returns. When the PC lands on one of these addresses, a small tracking state machine opens or closes a timed interval. Each closed interval is added to one bin of a result store.

There are three kinds of bin. An action bin holds the time spent inside that action. A guard bin, one per actor, holds evaluation time that ended by calling one of the actor's actions. A single overhead bin holds evaluation passes that were abandoned, without calling any action, when another evaluation began. Each bin keeps a saturating cycle total and a saturating count of the intervals it has received. All times are taken from one free-running cycle counter. The processor reads the bins back through a registered read port and can zero all of them with a clear strobe.

The tracking state machine has three states. IDLE means no interval is open. EVAL means an evaluation interval is open for the actor in `cur_actor`. ACTION means an action interval is open for `cur_action`. The transitions are:
- `start_eval`: IDLE to EVAL, on an evaluation-start match.
- `restart_eval`: EVAL to EVAL, on an evaluation-start match; the open pass is charged to the overhead bin.
- `enter_action`: EVAL to ACTION, on an action-entry match; the open pass is charged to the guard bin.
- `leave_action`: ACTION to IDLE, on the exit match of the current action; the action interval is charged to its action bin.

Top module: `pc_action_profiler`

## Requirements
- R1: After reset every bin reads a time of 0 and a count of 0.
- R2: A PC equal to a loaded evaluation-start address moves IDLE to EVAL. A later action-entry match while in EVAL adds the number of cycles between the two matches to the guard bin of the evaluating actor, at bin index N_ACTIONS + actor, and raises that bin's count by 1. The state then moves to ACTION.
- R3: In ACTION, a PC equal to the exit address of the current action adds the cycles since its entry match to action bin i (index i). The count rises by 1 and the state returns to IDLE.
- R4: An evaluation-start match while in EVAL adds the elapsed evaluation time to the overhead bin, at index N_ACTIONS + N_ACTORS, with count +1. It then restarts evaluation for the matched actor.
- R5: A PC that equals the PC of the previous cycle is a stall and never counts as a new match.
- R6: The following matches have no effect: action-entry and exit matches in IDLE, evaluation-start matches in ACTION, and exit matches of actions other than the current one.
- R7: Bin times saturate at all ones (2^ACC_W - 1) instead of wrapping, and stay there until cleared.
- R8: Bin counts saturate at 2^CNT_W - 1 and stay there until cleared.
- R9: A table write with `tbl_we` high stores `tbl_addr` at entry `tbl_idx` of the table chosen by `tbl_sel`: 0 for evaluation start, 1 for action entry, 2 for action exit, with 3 ignored. The new address matches from the next cycle and the old one no longer does. When several entries match, the lowest index wins.
- R10: A `clr` pulse zeroes every bin time and count.
- R11: `rd_time` and `rd_count` show bin `rd_addr` one clock after the address is presented. An address at or above the number of bins reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc | input | PC_W | Processor program-counter trace |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 2 | Table select: 0 evaluation start, 1 action entry, 2 action exit |
| tbl_idx | input | TIDX_W | Entry index within the chosen table |
| tbl_addr | input | PC_W | Address written into the table |
| clr | input | 1 | Zero all bins |
| rd_addr | input | BIN_W | Bin to read |
| rd_time | output | ACC_W | Accumulated cycles of the bin read |
| rd_count | output | CNT_W | Interval count of the bin read |

## Verification
The PC trace runs through four patterns:
- A plain evaluate, enter and leave pass with stalled PCs, which separates correct stall filtering from re-triggering on held addresses.
- An evaluation abandoned by a second evaluation start, which separates the overhead charge from the guard charge.
- A sequence of matches that must be ignored in IDLE and ACTION, including a foreign exit and an evaluation start inside an action, which exposes a tracker that closes on the wrong address.
- A table reload followed by long and repeated passes, which checks that the old address stops matching and that time and count saturate.

Narrow time and count widths are used so that both saturation limits are reached in a short run.

// File: rtl/profiler_pkg.sv
`timescale 1ns/1ps
package profiler_pkg;

    typedef enum logic [1:0] {
        TRK_IDLE   = 2'd0,
        TRK_EVAL   = 2'd1,
        TRK_ACTION = 2'd2
    } trk_state_e;

    typedef enum logic [1:0] {
        TSEL_EVAL  = 2'd0,
        TSEL_ENTRY = 2'd1,
        TSEL_EXIT  = 2'd2,
        TSEL_NONE  = 2'd3
    } tbl_sel_e;

endpackage

// File: rtl/pcp_addr_table.sv
`timescale 1ns/1ps
module pcp_addr_table #(
    parameter int N    = 4,
    parameter int PC_W = 32,
    parameter int IW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [PC_W-1:0] wr_addr,
    input  logic [PC_W-1:0] pc,
    output logic [N-1:0]    hit_vec
);
    logic [PC_W-1:0] addr_q [N];
    logic [N-1:0]    vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < N; i++) addr_q[i] <= '0;
        end else if (wr_en && (int'(wr_idx) < N)) begin
            addr_q[wr_idx] <= wr_addr;
            vld_q[wr_idx]  <= 1'b1;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = vld_q[g] && (addr_q[g] == pc);
    end

endmodule

// File: rtl/pcp_trace_front.sv
`timescale 1ns/1ps
module pcp_trace_front #(
    parameter int PC_W  = 32,
    parameter int ACC_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  pc,
    output logic             new_pc,
    output logic [ACC_W-1:0] ts
);
    logic [PC_W-1:0]  prev_pc_q;
    logic             seen_q;
    logic [ACC_W-1:0] ts_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_pc_q <= '0;
            seen_q    <= 1'b0;
            ts_q      <= '0;
        end else begin
            prev_pc_q <= pc;
            seen_q    <= 1'b1;
            ts_q      <= ts_q + 1'b1;
        end
    end

    assign new_pc = !seen_q || (pc != prev_pc_q);
    assign ts     = ts_q;

    // R5
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && pc == prev_pc_q) |-> !new_pc);

endmodule

// File: rtl/pcp_tracker.sv
`timescale 1ns/1ps
module pcp_tracker
    import profiler_pkg::*;
#(
    parameter int N_ACTORS  = 4,
    parameter int N_ACTIONS = 8,
    parameter int ACC_W     = 48,
    parameter int BIN_W     = 4,
    parameter int ACTOR_IW  = 2,
    parameter int ACT_IW    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 new_pc,
    input  logic [ACC_W-1:0]     ts,
    input  logic [N_ACTORS-1:0]  ev_vec,
    input  logic [N_ACTIONS-1:0] en_vec,
    input  logic [N_ACTIONS-1:0] ex_vec,
    output logic                 charge_en,
    output logic [BIN_W-1:0]     charge_bin,
    output logic [ACC_W-1:0]     charge_cyc
);
    localparam logic [BIN_W-1:0] GUARD_BASE = BIN_W'(N_ACTIONS);
    localparam logic [BIN_W-1:0] OVH_BIN    = BIN_W'(N_ACTIONS + N_ACTORS);

    trk_state_e          state_q, state_d;
    logic [ACTOR_IW-1:0] cur_actor_q, cur_actor_d;
    logic [ACT_IW-1:0]   cur_action_q, cur_action_d;
    logic [ACC_W-1:0]    start_q, start_d;

    logic                ev_hit, en_hit;
    logic [ACTOR_IW-1:0] ev_idx;
    logic [ACT_IW-1:0]   en_idx;

    // lowest index wins
    always_comb begin
        ev_hit = |ev_vec;
        ev_idx = '0;
        for (int i = N_ACTORS - 1; i >= 0; i--)
            if (ev_vec[i]) ev_idx = ACTOR_IW'(i);
        en_hit = |en_vec;
        en_idx = '0;
        for (int i = N_ACTIONS - 1; i >= 0; i--)
            if (en_vec[i]) en_idx = ACT_IW'(i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= TRK_IDLE;
            cur_actor_q  <= '0;
            cur_action_q <= '0;
            start_q      <= '0;
        end else begin
            state_q      <= state_d;
            cur_actor_q  <= cur_actor_d;
            cur_action_q <= cur_action_d;
            start_q      <= start_d;
        end
    end

    always_comb begin
        state_d      = state_q;
        cur_actor_d  = cur_actor_q;
        cur_action_d = cur_action_q;
        start_d      = start_q;
        charge_en    = 1'b0;
        charge_bin   = '0;
        charge_cyc   = ts - start_q;
        unique case (state_q)
            TRK_IDLE: begin
                if (new_pc && ev_hit) begin            // start_eval
                    state_d     = TRK_EVAL;
                    cur_actor_d = ev_idx;
                    start_d     = ts;
                end
            end
            TRK_EVAL: begin
                if (new_pc && ev_hit) begin            // restart_eval
                    charge_en   = 1'b1;
                    charge_bin  = OVH_BIN;
                    cur_actor_d = ev_idx;
                    start_d     = ts;
                end else if (new_pc && en_hit) begin   // enter_action
                    charge_en    = 1'b1;
                    charge_bin   = GUARD_BASE + BIN_W'(cur_actor_q);
                    cur_action_d = en_idx;
                    start_d      = ts;
                    state_d      = TRK_ACTION;
                end
            end
            TRK_ACTION: begin
                if (new_pc && ex_vec[cur_action_q]) begin  // leave_action
                    charge_en  = 1'b1;
                    charge_bin = BIN_W'(cur_action_q);
                    state_d    = TRK_IDLE;
                end
            end
            default: state_d = TRK_IDLE;
        endcase
    end

    // R2
    enter_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_EVAL && new_pc && !ev_hit && en_hit) |=> state_q == TRK_ACTION);
    // R3
    leave_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_ACTION && new_pc && ex_vec[cur_action_q]) |=> state_q == TRK_IDLE);
    // R4
    overhead_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (charge_en && charge_bin == OVH_BIN) |-> (state_q == TRK_EVAL && ev_hit));
    // R6
    action_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TRK_ACTION && !ex_vec[cur_action_q]) |=> state_q == TRK_ACTION);
    // R5
    stall_no_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !new_pc |-> !charge_en);

endmodule

// File: rtl/pcp_bin_store.sv
`timescale 1ns/1ps
module pcp_bin_store #(
    parameter int NB    = 13,
    parameter int BIN_W = 4,
    parameter int ACC_W = 48,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             charge_en,
    input  logic [BIN_W-1:0] charge_bin,
    input  logic [ACC_W-1:0] charge_cyc,
    input  logic [BIN_W-1:0] rd_addr,
    output logic [ACC_W-1:0] rd_time,
    output logic [CNT_W-1:0] rd_count
);
    logic [ACC_W-1:0] acc_q [NB];
    logic [CNT_W-1:0] cnt_q [NB];
    logic [ACC_W-1:0] rd_time_q;
    logic [CNT_W-1:0] rd_count_q;

    logic [ACC_W:0]   sum_w;
    logic [CNT_W:0]   inc_w;
    logic [ACC_W-1:0] acc_nx;
    logic [CNT_W-1:0] cnt_nx;
    logic             bin_ok;

    always_comb begin
        bin_ok = int'(charge_bin) < NB;
        sum_w  = bin_ok ? ({1'b0, acc_q[charge_bin]} + {1'b0, charge_cyc}) : '0;
        inc_w  = bin_ok ? ({1'b0, cnt_q[charge_bin]} + 1'b1) : '0;
        acc_nx = sum_w[ACC_W] ? {ACC_W{1'b1}} : sum_w[ACC_W-1:0];
        cnt_nx = inc_w[CNT_W] ? {CNT_W{1'b1}} : inc_w[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) begin
                acc_q[i] <= '0;
                cnt_q[i] <= '0;
            end
        end else if (clr) begin
            for (int i = 0; i < NB; i++) begin
                acc_q[i] <= '0;
                cnt_q[i] <= '0;
            end
        end else if (charge_en && bin_ok) begin
            acc_q[charge_bin] <= acc_nx;
            cnt_q[charge_bin] <= cnt_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_time_q  <= '0;
            rd_count_q <= '0;
        end else if (int'(rd_addr) < NB) begin
            rd_time_q  <= acc_q[rd_addr];
            rd_count_q <= cnt_q[rd_addr];
        end else begin
            rd_time_q  <= '0;
            rd_count_q <= '0;
        end
    end

    assign rd_time  = rd_time_q;
    assign rd_count = rd_count_q;

    for (genvar g = 0; g < NB; g++) begin : g_chk
        // R7
        time_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && acc_q[g] == {ACC_W{1'b1}}) |=> acc_q[g] == {ACC_W{1'b1}});
        // R8
        cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && cnt_q[g] == {CNT_W{1'b1}}) |=> cnt_q[g] == {CNT_W{1'b1}});
        // R10
        clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (acc_q[g] == '0 && cnt_q[g] == '0));
    end

endmodule

// File: rtl/pc_action_profiler.sv
`timescale 1ns/1ps
module pc_action_profiler
    import profiler_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int N_ACTORS  = 4,
    parameter int N_ACTIONS = 8,
    parameter int ACC_W     = 48,
    parameter int CNT_W     = 16,
    localparam int NB       = N_ACTIONS + N_ACTORS + 1,
    localparam int BIN_W    = $clog2(NB),
    localparam int ACTOR_IW = (N_ACTORS > 1) ? $clog2(N_ACTORS) : 1,
    localparam int ACT_IW   = (N_ACTIONS > 1) ? $clog2(N_ACTIONS) : 1,
    localparam int TIDX_W   = (ACTOR_IW > ACT_IW) ? ACTOR_IW : ACT_IW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   pc,
    input  logic              tbl_we,
    input  logic [1:0]        tbl_sel,
    input  logic [TIDX_W-1:0] tbl_idx,
    input  logic [PC_W-1:0]   tbl_addr,
    input  logic              clr,
    input  logic [BIN_W-1:0]  rd_addr,
    output logic [ACC_W-1:0]  rd_time,
    output logic [CNT_W-1:0]  rd_count
);
    logic                 new_pc;
    logic [ACC_W-1:0]     ts;
    logic [N_ACTORS-1:0]  ev_vec;
    logic [N_ACTIONS-1:0] en_vec, ex_vec;
    logic                 charge_en;
    logic [BIN_W-1:0]     charge_bin;
    logic [ACC_W-1:0]     charge_cyc;

    logic we_eval, we_entry, we_exit;
    assign we_eval  = tbl_we && (tbl_sel == TSEL_EVAL);
    assign we_entry = tbl_we && (tbl_sel == TSEL_ENTRY);
    assign we_exit  = tbl_we && (tbl_sel == TSEL_EXIT);

    pcp_trace_front #(.PC_W(PC_W), .ACC_W(ACC_W)) front_i (
        .clk(clk), .rst_n(rst_n), .pc(pc), .new_pc(new_pc), .ts(ts)
    );

    pcp_addr_table #(.N(N_ACTORS), .PC_W(PC_W), .IW(ACTOR_IW)) eval_tbl_i (
        .clk(clk), .rst_n(rst_n), .wr_en(we_eval), .wr_idx(tbl_idx[ACTOR_IW-1:0]),
        .wr_addr(tbl_addr), .pc(pc), .hit_vec(ev_vec)
    );

    pcp_addr_table #(.N(N_ACTIONS), .PC_W(PC_W), .IW(ACT_IW)) entry_tbl_i (
        .clk(clk), .rst_n(rst_n), .wr_en(we_entry), .wr_idx(tbl_idx[ACT_IW-1:0]),
        .wr_addr(tbl_addr), .pc(pc), .hit_vec(en_vec)
    );

    pcp_addr_table #(.N(N_ACTIONS), .PC_W(PC_W), .IW(ACT_IW)) exit_tbl_i (
        .clk(clk), .rst_n(rst_n), .wr_en(we_exit), .wr_idx(tbl_idx[ACT_IW-1:0]),
        .wr_addr(tbl_addr), .pc(pc), .hit_vec(ex_vec)
    );

    pcp_tracker #(
        .N_ACTORS(N_ACTORS), .N_ACTIONS(N_ACTIONS), .ACC_W(ACC_W),
        .BIN_W(BIN_W), .ACTOR_IW(ACTOR_IW), .ACT_IW(ACT_IW)
    ) trk_i (
        .clk(clk), .rst_n(rst_n), .new_pc(new_pc), .ts(ts),
        .ev_vec(ev_vec), .en_vec(en_vec), .ex_vec(ex_vec),
        .charge_en(charge_en), .charge_bin(charge_bin), .charge_cyc(charge_cyc)
    );

    pcp_bin_store #(.NB(NB), .BIN_W(BIN_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) bins_i (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .charge_en(charge_en), .charge_bin(charge_bin), .charge_cyc(charge_cyc),
        .rd_addr(rd_addr), .rd_time(rd_time), .rd_count(rd_count)
    );

    // R11
    rd_oob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_addr) >= NB) |=> (rd_time == '0 && rd_count == '0));

endmodule

// File: tb/pc_action_profiler_tb_top.sv
`timescale 1ns/1ps
module pc_action_profiler_tb_top;
    localparam int PC_W = 32;
    localparam int NACT = 4;
    localparam int NAX  = 8;
    localparam int AW   = 10;
    localparam int CW   = 3;
    localparam int NB   = NAX + NACT + 1;
    localparam int OVH  = NAX + NACT;
    localparam int TMAX = (1 << AW) - 1;
    localparam int CMAX = (1 << CW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] pc = 32'h50;
    logic            tbl_we = 1'b0;
    logic [1:0]      tbl_sel = 2'd0;
    logic [2:0]      tbl_idx = 3'd0;
    logic [PC_W-1:0] tbl_addr = '0;
    logic            clr = 1'b0;
    logic [3:0]      rd_addr = 4'd0;
    logic [AW-1:0]   rd_time;
    logic [CW-1:0]   rd_count;

    int checks = 0;
    int failures = 0;
    int exp_t [NB];
    int exp_c [NB];

    always #2 clk = ~clk;

    pc_action_profiler #(.PC_W(PC_W), .N_ACTORS(NACT), .N_ACTIONS(NAX),
                         .ACC_W(AW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pc(pc), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
        .tbl_idx(tbl_idx), .tbl_addr(tbl_addr), .clr(clr), .rd_addr(rd_addr),
        .rd_time(rd_time), .rd_count(rd_count)
    );

    task automatic hold(input logic [PC_W-1:0] a, input int n);
        @(negedge clk) pc = a;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [2:0] i, input logic [PC_W-1:0] a);
        @(negedge clk);
        tbl_we = 1'b1; tbl_sel = s; tbl_idx = i; tbl_addr = a;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic add(input int b, input int cyc);
        exp_t[b] = (exp_t[b] + cyc > TMAX) ? TMAX : exp_t[b] + cyc;
        exp_c[b] = (exp_c[b] + 1 > CMAX) ? CMAX : exp_c[b] + 1;
    endtask

    task automatic check_bin(input string req, input int b, input int et, input int ec);
        @(negedge clk) rd_addr = 4'(b);
        @(negedge clk);
        checks++;
        if (int'(rd_time) != et || int'(rd_count) != ec) begin
            failures++;
            $display("FAIL %s bin %0d: time=%0d count=%0d expected time=%0d count=%0d",
                     req, b, rd_time, rd_count, et, ec);
        end
    endtask

    task automatic check_all(input string req);
        for (int b = 0; b < NB; b++) check_bin(req, b, exp_t[b], exp_c[b]);
    endtask

    task automatic t_reset();
        check_all("R1");
    endtask

    task automatic t_load();
        wr(2'd0, 3'd0, 32'h100);  wr(2'd0, 3'd1, 32'h200);   // R9 eval table
        wr(2'd1, 3'd0, 32'h1000); wr(2'd2, 3'd0, 32'h10F0);  // R9 action 0
        wr(2'd1, 3'd1, 32'h1100); wr(2'd2, 3'd1, 32'h11F0);
        wr(2'd1, 3'd2, 32'h2000); wr(2'd2, 3'd2, 32'h20F0);
        wr(2'd3, 3'd3, 32'h104);  // select 3 ignored
    endtask

    task automatic t_basic();  // R2 R3 R5 stalls inside
        hold(32'h100, 3); hold(32'h104, 2);
        hold(32'h1000, 4); hold(32'h1004, 3);
        hold(32'h10F0, 1); hold(32'h50, 2);
        add(NAX + 0, 5); add(0, 7);
        check_bin("R2", NAX + 0, exp_t[NAX], exp_c[NAX]);
        check_bin("R3", 0, exp_t[0], exp_c[0]);
        check_bin("R5", OVH, 0, 0);
    endtask

    task automatic t_overhead();  // R4
        hold(32'h200, 6); hold(32'h100, 4);
        hold(32'h1100, 5); hold(32'h11F0, 1); hold(32'h50, 2);
        add(OVH, 6); add(NAX + 0, 4); add(1, 5);
        check_all("R4");
    endtask

    task automatic t_ignored();  // R6
        hold(32'h1000, 3); hold(32'h10F0, 1); hold(32'h50, 1);
        hold(32'h100, 2); hold(32'h2000, 3); hold(32'h10F0, 2);
        hold(32'h200, 2); hold(32'h20F0, 1); hold(32'h50, 2);
        add(NAX + 0, 2); add(2, 7);
        check_all("R6");
    endtask

    task automatic t_reload();  // R9
        wr(2'd1, 3'd0, 32'h3000);
        hold(32'h100, 1); hold(32'h1000, 2); hold(32'h3000, 2);
        hold(32'h10F0, 1); hold(32'h50, 2);
        add(NAX + 0, 3); add(0, 2);
        check_all("R9");
    endtask

    task automatic t_time_sat();  // R7
        for (int k = 0; k < 2; k++) begin
            hold(32'h100, 1); hold(32'h1100, 600);
            hold(32'h11F0, 1); hold(32'h50, 1);
            add(NAX + 0, 1); add(1, 600);
        end
        check_bin("R7", 1, TMAX, 3);
        check_all("R7");
    endtask

    task automatic t_cnt_sat();  // R8
        for (int k = 0; k < 3; k++) begin
            hold(32'h100, 1); hold(32'h3000, 1);
            hold(32'h10F0, 1); hold(32'h50, 1);
            add(NAX + 0, 1); add(0, 1);
        end
        check_bin("R8", NAX + 0, exp_t[NAX], CMAX);
        check_all("R8");
    endtask

    task automatic t_read_port();  // R11
        check_bin("R11", 13, 0, 0);
        check_bin("R11", 15, 0, 0);
        check_bin("R11", 2, exp_t[2], exp_c[2]);
    endtask

    task automatic t_clear();  // R10
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        for (int b = 0; b < NB; b++) begin exp_t[b] = 0; exp_c[b] = 0; end
        check_all("R10");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int b = 0; b < NB; b++) begin exp_t[b] = 0; exp_c[b] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_basic();
        t_overhead();
        t_ignored();
        t_reload();
        t_time_sat();
        t_cnt_sat();
        t_read_port();
        t_clear();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule